// File: doc/BRIEF.md
# Processor Main Control Decoder

This block turns the fields of one instruction into the control strobes that steer a single-cycle datapath. These strobes are the register-file write enable, the data-memory write enable, the write-back source select, the write-register and read-register selects, and the select that routes the return address into the register file. It has no clock and no state. Every output follows its inputs after the gate delay.

The instruction is presented as five fields:
- a two-bit class field, taken from instruction bits 27:26;
- a six-bit function field, taken from bits 25:20;
- the nibble from bits 7:4, which marks multiplies;
- the four-bit destination register index;
- a flag that says whether the instruction's condition passed.

A failed condition removes both write strobes. Compare and test commands do not write a result. A destination of the program counter also writes nothing, because the PC has its own update path. Multiply, branch-with-link and store each set their own register-select codes.

Top module: `ctrl_main_decoder`

## Requirements
- R1: When `cond_pass` is 0, `reg_we` and `mem_we` are both 0 for every instruction.
- R2: When `rd_idx` is 15, `reg_we` is 0 for every instruction.
- R3: For class 2'b00 (data processing), the command is `funct[4:1]`. Commands 4'b1000, 4'b1001, 4'b1010 and 4'b1011 (test, test-equal, compare, compare-negative) give `reg_we` = 0. Every other command gives `reg_we` = 1 when `cond_pass` is 1 and `rd_idx` is not 15.
- R4: For class 2'b01 (single memory transfer), the load bit is `funct[0]`. When that bit is 0 (a store), `reg_we` is 0 and `mem_we` equals `cond_pass`. `mem_we` is 0 for every other instruction.
- R5: For class 2'b10 (branch), the link bit is `funct[4]`. With the link bit at 0, `reg_we` is 0. With the link bit at 1, `reg_we` is 1 when `cond_pass` is 1 and `rd_idx` is not 15. The same rule holds for loads and for class 2'b11.
- R6: `wb_from_alu` is 0 (memory read data is written back) only for class 2'b01 with `funct[0]` = 1. It is 1 otherwise.
- R7: `wr_reg_sel` is 2'b10 (link register) for branch-with-link, 2'b00 for a multiply, and 2'b01 (destination field) otherwise.
- R8: `rd_reg_sel` is 2'b10 for a store (destination field read as store data), 2'b00 for a multiply, and 2'b01 (second operand field) otherwise.
- R9: `link_data_sel` is 1 only for branch-with-link. It is 0 otherwise.
- R10: An instruction is a multiply when the class is 2'b00, `funct[5:4]` is 2'b00 and `shift_nib` is 4'b1001. Any other `shift_nib` or `funct[5:4]` gives the plain data-processing selects.
- R11: `wb_from_alu`, `wr_reg_sel`, `rd_reg_sel` and `link_data_sel` do not depend on `cond_pass` or `rd_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_class | input | 2 | Instruction class, bits 27:26 |
| funct | input | 6 | Function field, bits 25:20 |
| shift_nib | input | 4 | Instruction bits 7:4, multiply marker |
| rd_idx | input | 4 | Destination register index |
| cond_pass | input | 1 | Condition of the instruction passed |
| reg_we | output | 1 | Register-file write enable |
| wb_from_alu | output | 1 | 1: ALU result written back, 0: memory read data |
| mem_we | output | 1 | Data-memory write enable |
| wr_reg_sel | output | 2 | Write-register select |
| rd_reg_sel | output | 2 | Read-register select |
| link_data_sel | output | 1 | Route return address to write data |

## Verification
The hardest case to reach is a multiply. It needs a data-processing class, both upper function bits clear and one exact pattern in the shift nibble, all at once. Near misses look like ordinary commands with identical write strobes, so only the select codes tell them apart. The stimulus therefore sweeps all 64 function values against three shift nibbles: the multiply pattern and two near misses. This sweep is crossed with every class, three destination indices (including 15) and both condition values. Directed table rows then pin the overlaps, such as a branch-with-link aimed at register 15, which still selects the link path while writing nothing.

// File: rtl/ctrl_dec_pkg.sv
package ctrl_dec_pkg;

    localparam int OP_W    = 2;
    localparam int FUNCT_W = 6;
    localparam int NIB_W   = 4;
    localparam int CMD_W   = 4;
    localparam int SEL_W   = 2;

    typedef enum logic [OP_W-1:0] {
        OPC_DATA   = 2'b00,
        OPC_MEMORY = 2'b01,
        OPC_BRANCH = 2'b10,
        OPC_OTHER  = 2'b11
    } op_class_e;

    localparam logic [CMD_W-1:0] CMD_CMPGRP_BASE = 4'b1000;
    localparam int               CMD_CMPGRP_N    = 4;
    localparam logic [NIB_W-1:0] MUL_NIB         = 4'b1001;

    localparam logic [SEL_W-1:0] WSEL_MUL  = 2'b00;
    localparam logic [SEL_W-1:0] WSEL_RD   = 2'b01;
    localparam logic [SEL_W-1:0] WSEL_LINK = 2'b10;
    localparam logic [SEL_W-1:0] RSEL_MUL  = 2'b00;
    localparam logic [SEL_W-1:0] RSEL_RM   = 2'b01;
    localparam logic [SEL_W-1:0] RSEL_RD   = 2'b10;

    typedef struct packed {
        logic is_data;
        logic is_mem;
        logic is_branch;
        logic is_load;
        logic is_store;
        logic is_link;
        logic is_mul;
        logic is_cmpgrp;
    } instr_kind_t;

    typedef struct packed {
        logic             wb_from_alu;
        logic [SEL_W-1:0] wr_sel;
        logic [SEL_W-1:0] rd_sel;
        logic             link_sel;
    } path_sel_t;

endpackage

// File: rtl/ctrl_kind_decode.sv
module ctrl_kind_decode
    import ctrl_dec_pkg::*;
(
    input  logic [OP_W-1:0]    op_class,
    input  logic [FUNCT_W-1:0] funct,
    input  logic [NIB_W-1:0]   shift_nib,
    output instr_kind_t        kind
);
    instr_kind_t      kind_d;
    logic [CMD_W-1:0] cmd;
    logic             cmp_hit;

    assign cmd = funct[4:1];

    always_comb begin
        cmp_hit = 1'b0;
        for (int i = 0; i < CMD_CMPGRP_N; i++) begin
            if (cmd == CMD_CMPGRP_BASE + CMD_W'(i)) cmp_hit = 1'b1;
        end
    end

    always_comb begin
        kind_d           = '0;
        kind_d.is_data   = (op_class == OPC_DATA);
        kind_d.is_mem    = (op_class == OPC_MEMORY);
        kind_d.is_branch = (op_class == OPC_BRANCH);
        kind_d.is_load   = kind_d.is_mem && funct[0];
        kind_d.is_store  = kind_d.is_mem && !funct[0];
        kind_d.is_link   = kind_d.is_branch && funct[4];
        kind_d.is_mul    = kind_d.is_data && (funct[5:4] == 2'b00)
                           && (shift_nib == MUL_NIB);
        kind_d.is_cmpgrp = kind_d.is_data && cmp_hit;
    end

    assign kind = kind_d;
endmodule

// File: rtl/ctrl_write_gate.sv
module ctrl_write_gate
    import ctrl_dec_pkg::*;
#(
    parameter int REG_IDX_W = 4,
    parameter int PC_IDX    = 15
) (
    input  instr_kind_t          kind,
    input  logic [REG_IDX_W-1:0] rd_idx,
    input  logic                 cond_pass,
    output logic                 reg_we,
    output logic                 mem_we
);
    localparam logic [REG_IDX_W-1:0] PC_CODE = REG_IDX_W'(PC_IDX);

    logic reg_we_d;
    logic mem_we_d;
    logic no_result;

    always_comb begin
        no_result = kind.is_cmpgrp || kind.is_store
                    || (kind.is_branch && !kind.is_link);
        reg_we_d  = cond_pass && (rd_idx != PC_CODE) && !no_result;
        mem_we_d  = cond_pass && kind.is_store;
    end

    assign reg_we = reg_we_d;
    assign mem_we = mem_we_d;
endmodule

// File: rtl/ctrl_path_select.sv
module ctrl_path_select
    import ctrl_dec_pkg::*;
(
    input  instr_kind_t kind,
    output path_sel_t   sel
);
    path_sel_t sel_d;

    always_comb begin
        sel_d.wb_from_alu = !kind.is_load;
        sel_d.link_sel    = kind.is_link;

        if (kind.is_link)     sel_d.wr_sel = WSEL_LINK;
        else if (kind.is_mul) sel_d.wr_sel = WSEL_MUL;
        else                  sel_d.wr_sel = WSEL_RD;

        if (kind.is_store)    sel_d.rd_sel = RSEL_RD;
        else if (kind.is_mul) sel_d.rd_sel = RSEL_MUL;
        else                  sel_d.rd_sel = RSEL_RM;
    end

    assign sel = sel_d;
endmodule

// File: rtl/ctrl_main_decoder.sv
module ctrl_main_decoder
    import ctrl_dec_pkg::*;
#(
    parameter int REG_IDX_W = 4,
    parameter int PC_IDX    = 15
) (
    input  logic [1:0]           op_class,
    input  logic [5:0]           funct,
    input  logic [3:0]           shift_nib,
    input  logic [REG_IDX_W-1:0] rd_idx,
    input  logic                 cond_pass,
    output logic                 reg_we,
    output logic                 wb_from_alu,
    output logic                 mem_we,
    output logic [1:0]           wr_reg_sel,
    output logic [1:0]           rd_reg_sel,
    output logic                 link_data_sel
);
    instr_kind_t kind;
    path_sel_t   sel;

    ctrl_kind_decode u_kind (
        .op_class  (op_class),
        .funct     (funct),
        .shift_nib (shift_nib),
        .kind      (kind)
    );

    ctrl_write_gate #(
        .REG_IDX_W (REG_IDX_W),
        .PC_IDX    (PC_IDX)
    ) u_gate (
        .kind      (kind),
        .rd_idx    (rd_idx),
        .cond_pass (cond_pass),
        .reg_we    (reg_we),
        .mem_we    (mem_we)
    );

    ctrl_path_select u_sel (
        .kind (kind),
        .sel  (sel)
    );

    assign wb_from_alu   = sel.wb_from_alu;
    assign wr_reg_sel    = sel.wr_sel;
    assign rd_reg_sel    = sel.rd_sel;
    assign link_data_sel = sel.link_sel;
endmodule

// File: rtl/ctrl_main_decoder_chk.sv
module ctrl_main_decoder_chk #(
    parameter int REG_IDX_W = 4,
    parameter int PC_IDX    = 15
) (
    input logic [1:0]           op_class,
    input logic [5:0]           funct,
    input logic [3:0]           shift_nib,
    input logic [REG_IDX_W-1:0] rd_idx,
    input logic                 cond_pass,
    input logic                 reg_we,
    input logic                 wb_from_alu,
    input logic                 mem_we,
    input logic [1:0]           wr_reg_sel,
    input logic [1:0]           rd_reg_sel,
    input logic                 link_data_sel
);
    always_comb begin
        AST_FAILED_COND_NO_WRITE: assert (cond_pass || (!reg_we && !mem_we)); // R1
        AST_PC_DEST_NO_REG_WRITE: assert (rd_idx != REG_IDX_W'(PC_IDX) || !reg_we); // R2
        AST_CMPGRP_NO_REG_WRITE: assert (!(op_class == 2'b00 && funct[4:3] == 2'b10) || !reg_we); // R3
        AST_MEM_WRITE_ONLY_STORE: assert (!mem_we || (op_class == 2'b01 && !funct[0] && cond_pass)); // R4
        AST_PLAIN_BRANCH_NO_WRITE: assert (!(op_class == 2'b10 && !funct[4]) || !reg_we); // R5
        AST_MEMDATA_ONLY_LOAD: assert (wb_from_alu || (op_class == 2'b01 && funct[0])); // R6
        AST_LINK_PAIRS_WRSEL: assert (link_data_sel == (wr_reg_sel == 2'b10)); // R7
        AST_RDSEL_CODE_LEGAL: assert (rd_reg_sel != 2'b11); // R8
        AST_LINK_ONLY_BRANCH: assert (!link_data_sel || op_class == 2'b10); // R9
        AST_MUL_SELS_TOGETHER: assert ((wr_reg_sel == 2'b00) == (rd_reg_sel == 2'b00)); // R10
        AST_MUL_NEEDS_NIBBLE: assert (wr_reg_sel != 2'b00 || shift_nib == 4'b1001); // R10
    end
endmodule

bind ctrl_main_decoder ctrl_main_decoder_chk #(
    .REG_IDX_W (REG_IDX_W),
    .PC_IDX    (PC_IDX)
) u_chk (
    .op_class      (op_class),
    .funct         (funct),
    .shift_nib     (shift_nib),
    .rd_idx        (rd_idx),
    .cond_pass     (cond_pass),
    .reg_we        (reg_we),
    .wb_from_alu   (wb_from_alu),
    .mem_we        (mem_we),
    .wr_reg_sel    (wr_reg_sel),
    .rd_reg_sel    (rd_reg_sel),
    .link_data_sel (link_data_sel)
);

// File: tb/ctrl_main_decoder_test.sv
module ctrl_main_decoder_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;
    localparam int VEC_W      = 25;
    localparam int N_TBL      = 18;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] op_class;
    logic [5:0] funct;
    logic [3:0] shift_nib;
    logic [3:0] rd_idx;
    logic       cond_pass;
    logic       reg_we, wb_from_alu, mem_we, link_data_sel;
    logic [1:0] wr_reg_sel, rd_reg_sel;

    int  applied = 0;
    int  miscmp  = 0;
    int  cycles  = 0;
    bit  done    = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ctrl_main_decoder uut (
        .op_class      (op_class),
        .funct         (funct),
        .shift_nib     (shift_nib),
        .rd_idx        (rd_idx),
        .cond_pass     (cond_pass),
        .reg_we        (reg_we),
        .wb_from_alu   (wb_from_alu),
        .mem_we        (mem_we),
        .wr_reg_sel    (wr_reg_sel),
        .rd_reg_sel    (rd_reg_sel),
        .link_data_sel (link_data_sel)
    );

    // {op, funct, nib, rd, cond,  we, wb, mem, wrs, rds, link}
    localparam logic [VEC_W-1:0] TBL [N_TBL] = '{
        {2'b00,6'b001000,4'b0000,4'd3, 1'b1, 1'b1,1'b1,1'b0,2'b01,2'b01,1'b0}, // R3 add
        {2'b00,6'b010101,4'b0000,4'd3, 1'b1, 1'b0,1'b1,1'b0,2'b01,2'b01,1'b0}, // R3 compare
        {2'b00,6'b010001,4'b0000,4'd3, 1'b1, 1'b0,1'b1,1'b0,2'b01,2'b01,1'b0}, // R3 test
        {2'b00,6'b010111,4'b0000,4'd3, 1'b1, 1'b0,1'b1,1'b0,2'b01,2'b01,1'b0}, // R3 cmp-neg
        {2'b00,6'b011000,4'b0000,4'd3, 1'b1, 1'b1,1'b1,1'b0,2'b01,2'b01,1'b0}, // R3 or
        {2'b00,6'b000000,4'b1001,4'd2, 1'b1, 1'b1,1'b1,1'b0,2'b00,2'b00,1'b0}, // R10 multiply
        {2'b00,6'b000000,4'b1011,4'd2, 1'b1, 1'b1,1'b1,1'b0,2'b01,2'b01,1'b0}, // R10 near miss
        {2'b00,6'b100000,4'b1001,4'd2, 1'b1, 1'b1,1'b1,1'b0,2'b01,2'b01,1'b0}, // R10 imm bit
        {2'b01,6'b011001,4'b0000,4'd4, 1'b1, 1'b1,1'b0,1'b0,2'b01,2'b01,1'b0}, // R6 load
        {2'b01,6'b011000,4'b0000,4'd4, 1'b1, 1'b0,1'b1,1'b1,2'b01,2'b10,1'b0}, // R4 store
        {2'b01,6'b011000,4'b0000,4'd4, 1'b0, 1'b0,1'b1,1'b0,2'b01,2'b10,1'b0}, // R1 store
        {2'b10,6'b100000,4'b0000,4'd6, 1'b1, 1'b0,1'b1,1'b0,2'b01,2'b01,1'b0}, // R5 branch
        {2'b10,6'b010000,4'b0000,4'd5, 1'b1, 1'b1,1'b1,1'b0,2'b10,2'b01,1'b1}, // R9 link
        {2'b10,6'b010000,4'b0000,4'd15,1'b1, 1'b0,1'b1,1'b0,2'b10,2'b01,1'b1}, // R2 link pc
        {2'b00,6'b001000,4'b0000,4'd15,1'b1, 1'b0,1'b1,1'b0,2'b01,2'b01,1'b0}, // R2 add pc
        {2'b01,6'b011001,4'b0000,4'd4, 1'b0, 1'b0,1'b0,1'b0,2'b01,2'b01,1'b0}, // R11 load
        {2'b11,6'b000000,4'b0000,4'd1, 1'b1, 1'b1,1'b1,1'b0,2'b01,2'b01,1'b0}, // R5 class 3
        {2'b00,6'b000000,4'b1001,4'd2, 1'b0, 1'b0,1'b1,1'b0,2'b00,2'b00,1'b0}  // R11 mul
    };

    function automatic logic [7:0] ref_out(input logic [1:0] op, input logic [5:0] f,
                                           input logic [3:0] nib, input logic [3:0] rd,
                                           input logic c);
        logic load, store, link, mul, cmpg, we, wb, mem, lk;
        logic [1:0] wrs, rds;
        load  = (op == 2'b01) && f[0];
        store = (op == 2'b01) && !f[0];
        link  = (op == 2'b10) && f[4];
        mul   = (op == 2'b00) && (f[5:4] == 2'b00) && (nib == 4'b1001);
        cmpg  = (op == 2'b00) && (f[4:1] >= 4'b1000) && (f[4:1] <= 4'b1011);
        we    = c && (rd != 4'd15) && !cmpg && !store && !((op == 2'b10) && !f[4]);
        mem   = c && store;
        wb    = !load;
        lk    = link;
        wrs   = link ? 2'b10 : (mul ? 2'b00 : 2'b01);
        rds   = store ? 2'b10 : (mul ? 2'b00 : 2'b01);
        return {we, wb, mem, wrs, rds, lk};
    endfunction

    task automatic compare(input logic [7:0] exp, input string tag);
        logic [7:0] act;
        act = {reg_we, wb_from_alu, mem_we, wr_reg_sel, rd_reg_sel, link_data_sel};
        applied++;
        if (act[7] !== exp[7]) begin
            miscmp++;
            $display("FAIL %s reg_we (R1 R2 R3 R5) op=%b f=%b rd=%0d c=%b act=%b exp=%b",
                     tag, op_class, funct, rd_idx, cond_pass, act[7], exp[7]);
        end
        if (act[6] !== exp[6]) begin
            miscmp++;
            $display("FAIL %s wb_from_alu (R6) act=%b exp=%b", tag, act[6], exp[6]);
        end
        if (act[5] !== exp[5]) begin
            miscmp++;
            $display("FAIL %s mem_we (R4) act=%b exp=%b", tag, act[5], exp[5]);
        end
        if (act[4:3] !== exp[4:3]) begin
            miscmp++;
            $display("FAIL %s wr_reg_sel (R7) act=%b exp=%b", tag, act[4:3], exp[4:3]);
        end
        if (act[2:1] !== exp[2:1]) begin
            miscmp++;
            $display("FAIL %s rd_reg_sel (R8) act=%b exp=%b", tag, act[2:1], exp[2:1]);
        end
        if (act[0] !== exp[0]) begin
            miscmp++;
            $display("FAIL %s link_data_sel (R9) act=%b exp=%b", tag, act[0], exp[0]);
        end
    endtask

    task automatic drive(input logic [1:0] op, input logic [5:0] f, input logic [3:0] nib,
                         input logic [3:0] rd, input logic c);
        @(negedge clk);
        op_class  = op;
        funct     = f;
        shift_nib = nib;
        rd_idx    = rd;
        cond_pass = c;
        #(CLK_PERIOD/4);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", applied, miscmp);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG && !done) begin
            miscmp++;
            $display("FAIL watchdog expired at cycle %0d", cycles);
            finish_run();
        end
    end

    initial begin
        // R1: state while reset is held, with condition low
        drive(2'b00, 6'b000000, 4'b0000, 4'd0, 1'b0);
        compare(8'b0_1_0_01_01_0, "R1 reset");
        repeat (2) @(negedge clk);
        rst = 1'b0;

        // directed table
        for (int i = 0; i < N_TBL; i++) begin
            drive(TBL[i][24:23], TBL[i][22:17], TBL[i][16:13], TBL[i][12:9], TBL[i][8]);
            compare(TBL[i][7:0], $sformatf("table row %0d", i));
        end

        // sweep against reference: R1 R2 R3 R4 R5 R6 R7 R8 R9 R10 R11
        for (int op = 0; op < 4; op++) begin
            for (int f = 0; f < 64; f++) begin
                for (int n = 0; n < 3; n++) begin
                    for (int r = 0; r < 3; r++) begin
                        for (int c = 0; c < 2; c++) begin
                            logic [3:0] nib, rd;
                            nib = (n == 0) ? 4'b1001 : ((n == 1) ? 4'b0000 : 4'b1011);
                            rd  = (r == 0) ? 4'd0 : ((r == 1) ? 4'd14 : 4'd15);
                            drive(2'(op), 6'(f), nib, rd, 1'(c));
                            compare(ref_out(2'(op), 6'(f), nib, rd, 1'(c)), "sweep");
                        end
                    end
                end
            end
        end

        // R11: selects stay put when only cond_pass and rd_idx move
        drive(2'b10, 6'b010000, 4'b0000, 4'd5, 1'b1);
        compare(8'b1_1_0_10_01_1, "R11 link base");
        drive(2'b10, 6'b010000, 4'b0000, 4'd15, 1'b0);
        compare(8'b0_1_0_10_01_1, "R11 link cond low pc");

        done = 1'b1;
        finish_run();
    end
endmodule